// File: doc/BRIEF.md
# Matrix Keyboard Make/Break Scanner

This block scans a 12-row by 8-column key matrix and turns key activity into 8-bit make and break codes for a host. A scan pass starts only on a frame tick. The pass drives one row number at a time on the row strobe and reads the column lines back through a two-flop synchroniser. It then decides whether anything changed. A pass emits at most one code.

Control, alt and the two shift keys each have their own tracked state. Every other key is handled through a single tracked slot: one non-modifier key is followed until it is released. When a make code is emitted, a debounce hold-off starts, and its length depends on the row of the key.

Codes go into a 14-slot ring queue. When the queue is full, new codes are dropped. Bytes leave the queue one at a time while the host is not busy, and each byte is marked by a one-cycle valid pulse. After reset, the first byte in the queue is 0xAA.

The scan FSM has five states:

- `S_IDLE`: waits for a tick. On a tick it either counts the debounce down or starts a pass.
- `S_DRIVE`: updates the row strobe.
- `S_SETTLE`: waits a fixed number of cycles so the synchronised columns can settle.
- `S_EVAL`: makes the decision for the current phase. It then moves to the next phase's `S_DRIVE`, to `S_EMIT`, or back to `S_IDLE`.
- `S_EMIT`: pushes one code and loads the debounce. It always returns to `S_IDLE`.

The phases, in order, are `PH_CTL`, `PH_ALT`, `PH_REL`, `PH_RS`, `PH_LS` and `PH_SRCH`. `PH_SRCH` repeats once per row.

Top module: `kbd_scanner`

## Requirements
- R1: The matrix is scanned only when `frame_tick` is high while the scanner is idle. If the debounce count is nonzero at that tick, the count is decremented by one and no rows are strobed.
- R2: Each pass checks, in this order: control, alt, release of the tracked key, right shift, left shift, then a search for a new key. The pass ends at the first code emitted. If the tracked key is still held, the pass ends at that point and no further checks run.
- R3: Control is pressed when any column of row 1 reads 1, and its make code is 29. Alt uses row 2 the same way, with make code 56. Right shift is row 3 column 2, make code 54. Left shift is row 4 column 1, make code 42. A code is emitted whenever a modifier's column state differs from its stored state. Each break code is the make code with bit 7 set.
- R4: The search walks rows 3 to 12 in ascending order, ignoring the right-shift column in row 3 and the left-shift column in row 4. The first row with any remaining column set is chosen, and the highest set column in that row becomes the tracked key.
- R5: A non-modifier key at row r and column c has index (r-3)*8+c, for 80 entries in all. Its make code is the index plus 1.
- R6: While a key is tracked, a 0 on its column in its row emits that key's code with bit 7 set and clears the tracking.
- R7: After a make code from rows 1 to 10, the next 2 ticks are consumed by debounce. After a make code from rows 11 or 12, the next 4 ticks are consumed. A break code loads no debounce.
- R8: The queue has 14 slots, so at most 13 bytes are pending. A code pushed while 13 bytes are pending is lost, and the bytes already queued are kept in order.
- R9: `scan_valid` rises for a single cycle only when `host_busy` was low at that clock edge and a byte was pending. `scan_data` holds the oldest pending byte while `scan_valid` is high. Two pulses never fall on adjacent cycles.
- R10: After reset, no modifier is pressed, no key is tracked, the debounce count is zero, `scan_valid` is low, and the only queued byte is 0xAA.
- R11: `row_strobe` carries the row number (0 to 12) in bits 5:2, and all its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle scan request |
| col_in | input | 8 | Column read-back, active high, asynchronous |
| host_busy | input | 1 | Host cannot accept a byte when high |
| row_strobe | output | 8 | Row select, row number in bits 5:2 |
| scan_data | output | 8 | Byte presented to the host |
| scan_valid | output | 1 | One-cycle marker for `scan_data` |

## Verification
The following input patterns are each compared against a behavioural model tick by tick:

- A lone control press and release, which separates modifier make and break codes from the debounce skipping.
- A two-column press in one row, which shows whether the highest column is chosen.
- A held right shift together with a row-3 key, which shows that the shift column is masked from the search and that modifier priority is respected.
- Shift changes made while a key is tracked, which prove that a held key blocks the shift checks.
- A row-12 key, which separates the long hold-off from the short one.
- Simultaneous control and alt changes, which show that only one code leaves per tick.
- A burst of toggles with the host held busy, which overfills the queue and shows which codes survive.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DRIVE,
        S_SETTLE,
        S_EVAL,
        S_EMIT
    } scan_state_t;

    typedef enum logic [2:0] {
        PH_CTL,
        PH_ALT,
        PH_REL,
        PH_RS,
        PH_LS,
        PH_SRCH
    } scan_phase_t;

    localparam logic [7:0] CODE_CTL   = 8'd29;
    localparam logic [7:0] CODE_ALT   = 8'd56;
    localparam logic [7:0] CODE_LSH   = 8'd42;
    localparam logic [7:0] CODE_RSH   = 8'd54;
    localparam logic [7:0] BREAK_FLAG = 8'h80;

    localparam int ROW_CTL   = 1;
    localparam int ROW_ALT   = 2;
    localparam int ROW_RSH   = 3;
    localparam int ROW_LSH   = 4;
    localparam int COL_RSH   = 2;
    localparam int COL_LSH   = 1;
    localparam int FIRST_KEY_ROW = 3;

    // Default make code for a non-modifier key index.
    function automatic logic [7:0] key_code(input int idx);
        return 8'(idx + 1);
    endfunction

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/kbd_codemap.sv
module kbd_codemap
    import kbd_pkg::*;
#(
    parameter int ENTRIES = 80,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       code
);
    logic [7:0] table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign table_q[g] = key_code(g);
    end

    always_comb begin
        code = 8'd0;
        if (int'(idx) < ENTRIES) code = table_q[idx];
    end
endmodule

// File: rtl/kbd_queue.sv
module kbd_queue #(
    parameter int         DEPTH = 14,
    parameter int         W     = 8,
    parameter logic [W-1:0] INIT = 8'hAA,
    localparam int        PTR_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         host_busy,
    output logic [W-1:0] dout,
    output logic         dvalid
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp, wp_nxt, rp_nxt;
    logic             pop;

    assign wp_nxt = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
    assign rp_nxt = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
    assign pop    = !dvalid && !host_busy && (wp != rp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            mem[0] <= INIT;
            wp     <= PTR_W'(1);
            rp     <= '0;
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                if (wp_nxt != rp) wp <= wp_nxt;
            end
            dvalid <= pop;
            if (pop) begin
                dout <= mem[rp];
                rp   <= rp_nxt;
            end
        end
    end

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wp_nxt == rp) |=> (wp == $past(wp)));

    // R9
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> !dvalid);

    // R9
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dvalid) |-> !$past(host_busy));
endmodule

// File: rtl/kbd_scan_fsm.sv
module kbd_scan_fsm
    import kbd_pkg::*;
#(
    parameter int ROWS     = 12,
    parameter int COLS     = 8,
    parameter int SETTLE   = 3,
    parameter int DB_SHORT = 2,
    parameter int DB_LONG  = 4,
    parameter int LONG_ROW = 11,
    localparam int ROW_W   = $clog2(ROWS + 1),
    localparam int COL_W   = $clog2(COLS),
    localparam int ENTRIES = (ROWS - FIRST_KEY_ROW + 1) * COLS,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int DB_W    = $clog2(DB_LONG + 1),
    localparam int CNT_W   = $clog2(SETTLE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic [COLS-1:0]  cols,
    output logic [ROW_W-1:0] row_sel,
    output logic             push,
    output logic [7:0]       code
);
    scan_state_t st, st_n;
    scan_phase_t ph, ph_n;
    logic [ROW_W-1:0] row_q, row_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [DB_W-1:0]  dbc_q, dbc_n;
    logic             ctl_q, ctl_n, alt_q, alt_n, rs_q, rs_n, ls_q, ls_n;
    logic [ROW_W-1:0] trk_row_q, trk_row_n, emit_row_q, emit_row_n;
    logic [COL_W-1:0] trk_bit_q, trk_bit_n;
    logic [IDX_W-1:0] trk_idx_q, trk_idx_n;
    logic [7:0]       code_q, code_n;

    logic [COLS-1:0]  srch_mask;
    logic [COL_W-1:0] hb;
    logic [IDX_W-1:0] cand_idx, map_idx;
    logic [7:0]       map_code;
    logic             any_col;

    // Search mask drops the shift columns of their rows.
    always_comb begin
        srch_mask = cols;
        if (int'(row_q) == ROW_RSH) srch_mask[COL_RSH] = 1'b0;
        if (int'(row_q) == ROW_LSH) srch_mask[COL_LSH] = 1'b0;
        hb = '0;
        for (int i = 0; i < COLS; i++) begin
            if (srch_mask[i]) hb = COL_W'(i);
        end
        cand_idx = IDX_W'((int'(row_q) - FIRST_KEY_ROW) * COLS + int'(hb));
    end

    assign any_col = |cols;
    assign map_idx = (ph == PH_SRCH) ? cand_idx : trk_idx_q;

    kbd_codemap #(.ENTRIES(ENTRIES)) u_map (
        .idx  (map_idx),
        .code (map_code)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            ph         <= PH_CTL;
            row_q      <= '0;
            cnt_q      <= '0;
            dbc_q      <= '0;
            ctl_q      <= 1'b0;
            alt_q      <= 1'b0;
            rs_q       <= 1'b0;
            ls_q       <= 1'b0;
            trk_row_q  <= '0;
            trk_bit_q  <= '0;
            trk_idx_q  <= '0;
            emit_row_q <= '0;
            code_q     <= '0;
        end else begin
            st         <= st_n;
            ph         <= ph_n;
            row_q      <= row_n;
            cnt_q      <= cnt_n;
            dbc_q      <= dbc_n;
            ctl_q      <= ctl_n;
            alt_q      <= alt_n;
            rs_q       <= rs_n;
            ls_q       <= ls_n;
            trk_row_q  <= trk_row_n;
            trk_bit_q  <= trk_bit_n;
            trk_idx_q  <= trk_idx_n;
            emit_row_q <= emit_row_n;
            code_q     <= code_n;
        end
    end

    // Next state and outputs
    always_comb begin
        st_n       = st;
        ph_n       = ph;
        row_n      = row_q;
        cnt_n      = cnt_q;
        dbc_n      = dbc_q;
        ctl_n      = ctl_q;
        alt_n      = alt_q;
        rs_n       = rs_q;
        ls_n       = ls_q;
        trk_row_n  = trk_row_q;
        trk_bit_n  = trk_bit_q;
        trk_idx_n  = trk_idx_q;
        emit_row_n = emit_row_q;
        code_n     = code_q;

        unique case (st)
            S_IDLE: begin
                if (frame_tick) begin
                    if (dbc_q != '0) begin
                        dbc_n = dbc_q - DB_W'(1);
                    end else begin
                        st_n  = S_DRIVE;
                        ph_n  = PH_CTL;
                        row_n = ROW_W'(ROW_CTL);
                    end
                end
            end
            S_DRIVE: begin
                st_n  = S_SETTLE;
                cnt_n = '0;
            end
            S_SETTLE: begin
                if (int'(cnt_q) >= SETTLE - 1) st_n = S_EVAL;
                else cnt_n = cnt_q + CNT_W'(1);
            end
            S_EVAL: begin
                unique case (ph)
                    PH_CTL: begin
                        if (any_col != ctl_q) begin
                            ctl_n      = any_col;
                            code_n     = CODE_CTL | (any_col ? 8'h00 : BREAK_FLAG);
                            emit_row_n = ROW_W'(ROW_CTL);
                            st_n       = S_EMIT;
                        end else begin
                            st_n  = S_DRIVE;
                            ph_n  = PH_ALT;
                            row_n = ROW_W'(ROW_ALT);
                        end
                    end
                    PH_ALT: begin
                        if (any_col != alt_q) begin
                            alt_n      = any_col;
                            code_n     = CODE_ALT | (any_col ? 8'h00 : BREAK_FLAG);
                            emit_row_n = ROW_W'(ROW_ALT);
                            st_n       = S_EMIT;
                        end else if (trk_row_q != '0) begin
                            st_n  = S_DRIVE;
                            ph_n  = PH_REL;
                            row_n = trk_row_q;
                        end else begin
                            st_n  = S_DRIVE;
                            ph_n  = PH_RS;
                            row_n = ROW_W'(ROW_RSH);
                        end
                    end
                    PH_REL: begin
                        if (!cols[trk_bit_q]) begin
                            code_n     = map_code | BREAK_FLAG;
                            emit_row_n = trk_row_q;
                            trk_row_n  = '0;
                            st_n       = S_EMIT;
                        end else begin
                            st_n = S_IDLE;
                        end
                    end
                    PH_RS: begin
                        if (cols[COL_RSH] != rs_q) begin
                            rs_n       = cols[COL_RSH];
                            code_n     = CODE_RSH | (cols[COL_RSH] ? 8'h00 : BREAK_FLAG);
                            emit_row_n = ROW_W'(ROW_RSH);
                            st_n       = S_EMIT;
                        end else begin
                            st_n  = S_DRIVE;
                            ph_n  = PH_LS;
                            row_n = ROW_W'(ROW_LSH);
                        end
                    end
                    PH_LS: begin
                        if (cols[COL_LSH] != ls_q) begin
                            ls_n       = cols[COL_LSH];
                            code_n     = CODE_LSH | (cols[COL_LSH] ? 8'h00 : BREAK_FLAG);
                            emit_row_n = ROW_W'(ROW_LSH);
                            st_n       = S_EMIT;
                        end else begin
                            st_n  = S_DRIVE;
                            ph_n  = PH_SRCH;
                            row_n = ROW_W'(FIRST_KEY_ROW);
                        end
                    end
                    PH_SRCH: begin
                        if (srch_mask != '0) begin
                            trk_row_n  = row_q;
                            trk_bit_n  = hb;
                            trk_idx_n  = cand_idx;
                            code_n     = map_code;
                            emit_row_n = row_q;
                            st_n       = S_EMIT;
                        end else if (int'(row_q) >= ROWS) begin
                            st_n = S_IDLE;
                        end else begin
                            st_n  = S_DRIVE;
                            row_n = row_q + ROW_W'(1);
                        end
                    end
                    default: st_n = S_IDLE;
                endcase
            end
            S_EMIT: begin
                st_n = S_IDLE;
                if (!code_q[7]) begin
                    dbc_n = (int'(emit_row_q) >= LONG_ROW) ? DB_W'(DB_LONG) : DB_W'(DB_SHORT);
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    assign push    = (st == S_EMIT);
    assign code    = code_q;
    assign row_sel = row_q;

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !frame_tick) |=> (st == S_IDLE));

    // R1
    db_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && frame_tick && dbc_q != '0) |=>
        (st == S_IDLE && dbc_q == $past(dbc_q) - DB_W'(1)));

    // R2
    one_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (st == S_IDLE && !push));

    // R7
    db_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !code_q[7]) |=> (dbc_q != '0));

    // R7
    no_db_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && code_q[7]) |=> (dbc_q == '0));
endmodule

// File: rtl/kbd_scanner.sv
module kbd_scanner #(
    parameter int ROWS     = 12,
    parameter int COLS     = 8,
    parameter int QDEPTH   = 14,
    parameter int SETTLE   = 3,
    parameter int DB_SHORT = 2,
    parameter int DB_LONG  = 4,
    parameter int LONG_ROW = 11,
    localparam int ROW_W   = $clog2(ROWS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    input  logic [COLS-1:0] col_in,
    input  logic            host_busy,
    output logic [7:0]      row_strobe,
    output logic [7:0]      scan_data,
    output logic            scan_valid
);
    logic [COLS-1:0]  cols_s;
    logic [ROW_W-1:0] row_sel;
    logic             push;
    logic [7:0]       code;

    kbd_sync #(.W(COLS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (col_in),
        .d_sync  (cols_s)
    );

    kbd_scan_fsm #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .SETTLE   (SETTLE),
        .DB_SHORT (DB_SHORT),
        .DB_LONG  (DB_LONG),
        .LONG_ROW (LONG_ROW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .cols       (cols_s),
        .row_sel    (row_sel),
        .push       (push),
        .code       (code)
    );

    kbd_queue #(
        .DEPTH (QDEPTH),
        .W     (8),
        .INIT  (8'hAA)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .din       (code),
        .host_busy (host_busy),
        .dout      (scan_data),
        .dvalid    (scan_valid)
    );

    always_comb begin
        row_strobe = '0;
        row_strobe[ROW_W+1:2] = row_sel;
    end
endmodule

// File: tb/kbd_scanner_test.sv
module kbd_scanner_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       host_busy = 1'b0;
    logic [7:0] col_in;
    logic [7:0] row_strobe, scan_data;
    logic       scan_valid;

    logic [7:0] km [0:12];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic prev_valid = 1'b0;
    logic in_reset = 1'b1;

    int    expq[$];
    string reqq[$];

    int m_dbc, m_trow, m_tbit;
    bit m_ctl, m_alt, m_rs, m_ls;

    always #4 clk = ~clk;

    assign col_in = (row_strobe[5:2] <= 4'd12) ? km[row_strobe[5:2]] : 8'h00;

    kbd_scanner uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .col_in     (col_in),
        .host_busy  (host_busy),
        .row_strobe (row_strobe),
        .scan_data  (scan_data),
        .scan_valid (scan_valid)
    );

    task automatic fail_msg(input string req, input int act, input int exp);
        errors++;
        $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    endtask

    task automatic emit(input int c, input int row, input string req);
        if (expq.size() < 13) begin
            expq.push_back(c);
            reqq.push_back(req);
        end
        if (c < 128) m_dbc = (row >= 11) ? 4 : 2;
    endtask

    // Behavioural reference for one frame tick
    task automatic model_tick();
        bit p;
        int m, hb;
        if (m_dbc > 0) begin
            m_dbc--;
            return;
        end
        p = (km[1] != 0);
        if (p != m_ctl) begin m_ctl = p; emit(p ? 29 : 157, 1, "R3"); return; end
        p = (km[2] != 0);
        if (p != m_alt) begin m_alt = p; emit(p ? 56 : 184, 2, "R3"); return; end
        if (m_trow != 0) begin
            if (km[m_trow][m_tbit] == 1'b0) begin
                emit(((m_trow - 3) * 8 + m_tbit + 1) + 128, m_trow, "R6");
                m_trow = 0;
            end
            return;
        end
        p = km[3][2];
        if (p != m_rs) begin m_rs = p; emit(p ? 54 : 182, 3, "R3"); return; end
        p = km[4][1];
        if (p != m_ls) begin m_ls = p; emit(p ? 42 : 170, 4, "R3"); return; end
        for (int r = 3; r <= 12; r++) begin
            m = km[r];
            if (r == 3) m = m & 8'hFB;
            if (r == 4) m = m & 8'hFD;
            if (m != 0) begin
                hb = 0;
                for (int b = 0; b < 8; b++) if (m[b]) hb = b;
                m_trow = r;
                m_tbit = hb;
                emit((r - 3) * 8 + hb + 1, r, "R5");
                return;
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        frame_tick = 1'b1;
        model_tick();
        @(negedge clk);
        frame_tick = 1'b0;
        repeat (120) @(negedge clk);
    endtask

    task automatic drain();
        repeat (200) @(negedge clk);
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        checks++;
        if (row_strobe[1:0] != 2'b00 || row_strobe[7:6] != 2'b00 || row_strobe[5:2] > 4'd12)
            fail_msg("R11", row_strobe, {2'b00, row_strobe[5:2], 2'b00});
        if (in_reset) begin
            checks++;
            if (scan_valid !== 1'b0 || row_strobe !== 8'h00) fail_msg("R10", scan_valid, 0);
        end else if (scan_valid) begin
            checks++;
            if (prev_valid) fail_msg("R9", 2, 1);
            if (host_busy) fail_msg("R9", host_busy, 0);
            if (expq.size() == 0) begin
                fail_msg("R8", scan_data, -1);
            end else begin
                if (scan_data != expq[0]) fail_msg(reqq[0], scan_data, expq[0]);
                void'(expq.pop_front());
                void'(reqq.pop_front());
            end
        end
        prev_valid = scan_valid;
    end

    initial begin
        for (int r = 0; r <= 12; r++) km[r] = 8'h00;
        m_dbc = 0; m_trow = 0; m_tbit = 0;
        m_ctl = 0; m_alt = 0; m_rs = 0; m_ls = 0;
        // R10: the queue starts with 0xAA
        expq.push_back(8'hAA);
        reqq.push_back("R10");
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        in_reset = 1'b0;
        drain();

        // R3, R7, R1: control make, debounce ticks consumed, then break
        km[1] = 8'h01; tick();
        km[1] = 8'h00; tick(); tick(); tick();
        // alt make and break
        km[2] = 8'h80; tick(); tick(); tick();
        km[2] = 8'h00; tick();

        // R4, R5, R6: two columns in row 5, highest chosen, held, released
        km[5] = 8'h48; tick(); tick(); tick(); tick();
        km[5] = 8'h00; tick();

        // R4, R2: right shift then a row-3 key under the masked column
        km[3] = 8'h05; tick(); tick(); tick(); tick(); tick();
        km[3] = 8'h00; tick(); tick(); tick();

        // R2: a held key blocks the shift checks until released
        km[7] = 8'h02; tick(); tick(); tick();
        km[4] = 8'h02; tick(); tick();
        km[7] = 8'h00; tick(); tick(); tick(); tick();
        km[4] = 8'h00; tick(); tick(); tick();

        // R7: row 12 key gives the long hold-off
        km[12] = 8'h10; tick();
        km[12] = 8'h00; tick(); tick(); tick(); tick(); tick(); tick();
        // row 11 key
        km[11] = 8'h01; tick(); tick();
        km[11] = 8'h00; tick(); tick(); tick(); tick(); tick();

        // R2: control and alt change on the same tick, one code each
        km[1] = 8'h04; km[2] = 8'h04; tick(); tick(); tick(); tick(); tick(); tick();
        km[1] = 8'h00; km[2] = 8'h00; tick(); tick();
        drain();

        // R8: overfill the queue with the host busy, then drain
        @(negedge clk) host_busy = 1'b1;
        for (int i = 0; i < 60; i++) begin
            km[1] = (i % 2 == 0) ? 8'h01 : 8'h00;
            tick();
        end
        km[1] = 8'h00;
        tick(); tick(); tick();
        @(negedge clk) host_busy = 1'b0;
        drain();

        // R9: busy asserted for a while then cleared
        km[9] = 8'h20; tick();
        @(negedge clk) host_busy = 1'b1;
        km[9] = 8'h00; tick(); tick(); tick();
        @(negedge clk) host_busy = 1'b0;
        drain();

        checks++;
        if (expq.size() != 0) fail_msg("R8", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule